// File: doc/BRIEF.md
# Eight-Bit ALU With Condition Flags

This block is the arithmetic and logic unit of a small 8-bit processor datapath. Each cycle it takes two operands and a 4-bit opcode. One clock later it presents an 8-bit result, a next-state flag nibble (zero, negative, carry, overflow) and a flag-update enable. The enable tells the surrounding core whether the flag register should take the new nibble. The block does not hold the flags and does not access the register file.

Every operation is computed combinationally within the cycle, and a single output register stage follows. The operations are:

- addition, subtraction and compare, which share one adder;
- the three bitwise operations;
- single-bit logical shifts;
- a truncated multiply built as a shift-add array;
- an unsigned divide built as an unrolled restoring array, one stage per quotient bit.

Opcodes outside the defined set produce a zero result and leave the flags untouched.

Top module: `alu8_core`

## Requirements
- R1: Opcode 0 (ADD) yields res_o = (a+b) mod 256. C is the carry out of bit 7. V is bit 7 of ((a^r)&(b^r)).
- R2: Opcode 1 (SUB) yields res_o = (a-b) mod 256, formed as a + ~b + 1. C=1 exactly when a >= b unsigned (no borrow). V is bit 7 of ((a^b)&(a^r)).
- R3: Opcode 9 (CMP) gives the same flags as SUB on the same operands, and res_o is 0.
- R4: Opcodes 2, 3 and 4 yield a&b, a|b and a^b respectively, with flag_we_o low.
- R5: Opcode 5 yields a shifted left by one and opcode 6 yields a shifted right by one. Both fill with zero, and b has no effect on the result.
- R6: Opcode 7 (MUL) yields the low 8 bits of the unsigned product a*b, with C=0 and V=0.
- R7: Opcode 8 (DIV) yields the unsigned quotient floor(a/b). When b=0 the result is 0xFF.
- R8: flags_o is {Z,N,C,V} with Z at bit 3 and V at bit 0. For ADD, SUB and MUL, Z=1 iff res_o is zero and N equals res_o bit 7. For CMP, Z and N are taken from the difference a-b.
- R9: flag_we_o is 1 only for opcodes 0, 1, 7 and 9. Whenever flag_we_o is 0, flags_o is 0.
- R10: Opcodes 10 to 15 yield res_o = 0 and flag_we_o = 0.
- R11: Outputs appear one clock after the inputs are presented. While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand (divisor, subtrahend) |
| res_o | output | 8 | Registered result |
| flags_o | output | 4 | Registered next flags {Z,N,C,V} |
| flag_we_o | output | 1 | Registered flag-update enable |

## Verification
The hardest behaviour to reach is the divider's stage-by-stage restore decision. The path differs when the shifted partial remainder lands exactly on the divisor, and when the divisor is above 128 with only the final stage able to subtract. These cases sit among operand pairs, not at obvious edges. The bench therefore drives every one of the 65,536 operand pairs into DIV, with b=0 included. For the other opcodes it pairs all 256 values of a with a set of b values chosen for carry, sign-overflow and zero-result boundaries.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SHL = 4'd5,
    OP_SHR = 4'd6,
    OP_MUL = 4'd7,
    OP_DIV = 4'd8,
    OP_CMP = 4'd9
  } op_e;

  localparam int FLAG_Z = 3;
  localparam int FLAG_N = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o
);
  logic [W-1:0] bx;
  logic [W:0]   full;

  assign bx    = sub_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, sub_i};
  assign sum_o = full[W-1:0];
  assign c_o   = full[W];
  // signed overflow: operands agree in sign, sum disagrees
  assign v_o   = (a_i[W-1] == bx[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu8_mul.sv
module alu8_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);
  logic [W-1:0] acc [W+1];

  assign acc[0] = '0;
  for (genvar j = 0; j < W; j++) begin : g_row
    logic [W-1:0] pp;
    assign pp       = b_i[j] ? (a_i << j) : '0;
    assign acc[j+1] = acc[j] + pp;
  end
  assign p_o = acc[W];
endmodule

// File: rtl/alu8_div.sv
module alu8_div #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] q_o
);
  localparam int RW = W + 1;

  logic [RW-1:0] rem [W+1];

  assign rem[0] = '0;
  for (genvar s = 0; s < W; s++) begin : g_stage
    logic [RW-1:0] sh;
    logic          ge;
    assign sh   = {rem[s][RW-2:0], a_i[W-1-s]};
    assign ge   = sh >= {1'b0, b_i};
    assign rem[s+1] = ge ? (sh - {1'b0, b_i}) : sh;
    assign q_o[W-1-s] = ge;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic [3:0]   flags_o,
  output logic         flag_we_o
);
  logic [W-1:0] as_sum, mul_p, div_q;
  logic         as_c, as_v, as_sub;

  logic [W-1:0] res_d;
  logic [3:0]   flags_d;
  logic         we_d;

  assign as_sub = (op_i == OP_SUB) || (op_i == OP_CMP);

  alu8_addsub #(.W(W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(as_sub),
    .sum_o(as_sum), .c_o(as_c), .v_o(as_v)
  );

  alu8_mul #(.W(W)) u_mul (.a_i(a_i), .b_i(b_i), .p_o(mul_p));

  alu8_div #(.W(W)) u_div (.a_i(a_i), .b_i(b_i), .q_o(div_q));

  always_comb begin
    res_d   = '0;
    flags_d = '0;
    we_d    = 1'b0;
    case (op_i)
      OP_ADD, OP_SUB: begin
        res_d   = as_sum;
        flags_d = {as_sum == '0, as_sum[W-1], as_c, as_v};
        we_d    = 1'b1;
      end
      OP_CMP: begin
        flags_d = {as_sum == '0, as_sum[W-1], as_c, as_v};
        we_d    = 1'b1;
      end
      OP_AND: res_d = a_i & b_i;
      OP_OR:  res_d = a_i | b_i;
      OP_XOR: res_d = a_i ^ b_i;
      OP_SHL: res_d = {a_i[W-2:0], 1'b0};
      OP_SHR: res_d = {1'b0, a_i[W-1:1]};
      OP_MUL: begin
        res_d   = mul_p;
        flags_d = {mul_p == '0, mul_p[W-1], 2'b00};
        we_d    = 1'b1;
      end
      OP_DIV: res_d = div_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      flags_o   <= '0;
      flag_we_o <= 1'b0;
    end else begin
      res_o     <= res_d;
      flags_o   <= flags_d;
      flag_we_o <= we_d;
    end
  end

  assert_we_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADD || op_i == OP_SUB || op_i == OP_MUL || op_i == OP_CMP) |=> flag_we_o);

  assert_we_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_o |-> (flags_o == 4'b0000));

  assert_mul_cv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MUL) |=> (flags_o[FLAG_C] == 1'b0 && flags_o[FLAG_V] == 1'b0));

  assert_div_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_DIV && b_i == '0) |=> (res_o == {W{1'b1}}));

  assert_high_op_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i >= 4'd10) |=> (res_o == '0 && !flag_we_o));

  assert_zero_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_o && $past(op_i) != OP_CMP) |-> (flags_o[FLAG_Z] == (res_o == '0)));

  assert_shl_lsb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SHL) |=> (res_o[0] == 1'b0));
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] a_i = '0;
  logic [7:0] b_i = '0;
  logic [7:0] res_o;
  logic [3:0] flags_o;
  logic       flag_we_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  alu8_core u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .res_o(res_o), .flags_o(flags_o), .flag_we_o(flag_we_o)
  );

  function automatic string op_tag(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3, 4: return "R4";
      5, 6: return "R5";
      7: return "R6";
      8: return "R7";
      9: return "R3";
      default: return "R10";
    endcase
  endfunction

  // expected {res, flags, we} from arithmetic definitions
  task automatic model(input int op, input int a, input int b,
                       output int er, output int ef, output int ew);
    int r, z, n, c, v, d;
    er = 0; ef = 0; ew = 0;
    case (op)
      0: begin
        r = (a + b) & 255; c = (a + b) > 255;
        v = (((a ^ r) & (b ^ r)) >> 7) & 1;
        er = r; ew = 1;
        ef = ((r == 0) << 3) | (((r >> 7) & 1) << 2) | (c << 1) | v;
      end
      1, 9: begin
        d = (a - b) & 255; c = a >= b;
        v = (((a ^ b) & (a ^ d)) >> 7) & 1;
        er = (op == 1) ? d : 0; ew = 1;
        ef = ((d == 0) << 3) | (((d >> 7) & 1) << 2) | (c << 1) | v;
      end
      2: er = a & b;
      3: er = a | b;
      4: er = a ^ b;
      5: er = (a << 1) & 255;
      6: er = a >> 1;
      7: begin
        r = (a * b) & 255; er = r; ew = 1;
        z = r == 0; n = (r >> 7) & 1;
        ef = (z << 3) | (n << 2);
      end
      8: er = (b == 0) ? 255 : a / b;
      default: ;
    endcase
  endtask

  // drive at negedge, registered result visible at next negedge
  task automatic run_vec(input int op, input int a, input int b);
    int er, ef, ew;
    op_i = op[3:0]; a_i = a[7:0]; b_i = b[7:0];
    model(op, a, b, er, ef, ew);
    @(negedge clk_i);
    checks++;
    if (res_o !== er[7:0]) begin
      failures++;
      $display("FAIL %s res op=%0d a=%0d b=%0d actual=%0h expected=%0h",
               op_tag(op), op, a, b, res_o, er[7:0]);
    end else if (flags_o !== ef[3:0]) begin
      failures++;
      $display("FAIL %s/R8 flags op=%0d a=%0d b=%0d actual=%b expected=%b",
               op_tag(op), op, a, b, flags_o, ef[3:0]);
    end else if (flag_we_o !== ew[0]) begin
      failures++;
      $display("FAIL R9 we op=%0d a=%0d b=%0d actual=%b expected=%b",
               op, a, b, flag_we_o, ew[0]);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int bset [16] = '{0, 1, 2, 3, 7, 10, 15, 16, 64, 85, 127, 128, 129, 170, 254, 255};
    op_i = 4'd0; a_i = 8'd200; b_i = 8'd100;
    repeat (3) @(negedge clk_i);
    // R11: reset holds outputs at zero
    checks++;
    if (res_o !== 8'h00 || flags_o !== 4'h0 || flag_we_o !== 1'b0) begin
      failures++;
      $display("FAIL R11 reset actual=%h/%b/%b expected=00/0000/0",
               res_o, flags_o, flag_we_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11: one-cycle latency, ADD 200+100 = 44 with carry
    run_vec(0, 200, 100);

    for (int op = 0; op < 10; op++) begin
      if (op == 8) continue;
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 16; k++)
          run_vec(op, a, bset[k]);
    end
    // R7: exhaustive divide, including b = 0
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        run_vec(8, a, b);
    // R10: undefined opcodes
    for (int op = 10; op < 16; op++)
      for (int a = 0; a < 256; a++)
        run_vec(op, a, 255 - a);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule